// File: doc/BRIEF.md
# Four-Channel Sinc3 Decimator with Fast Threshold Comparators

This block turns the 1-bit streams of four isolated delta-sigma current-shunt modulators into signed current words. Each channel samples its data bit on the rising edge of its own modulator clock. The bit is mapped to +1 or -1 and passed through a third-order sinc decimator: three integrators run at the bit rate and three comb differentiators run at the decimated rate. The decimation ratio can be set at run time. The primary result is not streamed out. It is latched only when a PWM-centre trigger pulse arrives, so the word that is read out is the average current over the control cycle.

Next to the primary filter, each channel has a second, short sinc3 filter with its own small ratio. Its output is compared with a shared high threshold and a shared low threshold, and it is watched for a change of sign. The result is three per-channel flags (over-current, under-current and zero crossing). Each flag stays set until it is cleared for that channel.

After reset, and after any change of a decimation ratio, a filter discards its first three decimated outputs while its state settles. A trigger that comes between decimation points returns the last complete result.

Top module: `sdf_top`

## Requirements
- R1: While reset is held, every bit of `dataValid`, `flagHigh`, `flagLow`, `flagZero` and `dataOut` is 0.
- R2: Each modulator bit is mapped as 1 → +1 and 0 → -1. With a steady all-ones stream and primary ratio N, the captured word is +N³, in two's complement with W bits (32768 at N=32). A steady all-zeros stream gives -N³.
- R3: A stream that alternates 0,1 gives a captured word of 0. A stream repeating 1,1,1,0 with N a multiple of 4 gives N³/2.
- R4: The four channels are independent. Different streams on different channels give each channel its own result in the same capture.
- R5: When `pwmTrig` is high at a clock edge, each channel that holds a settled result loads it into `dataOut` and drives `dataValid` high for exactly that one following cycle. `dataOut` changes only together with a strobe.
- R6: After reset the first three decimated outputs of a filter are not trusted. A trigger that comes before the fourth output gives no strobe.
- R7: A change of `primOsr` restarts the decimation count and the settling count. A trigger that comes before four new outputs gives no strobe. After that, results are scaled by the new ratio.
- R8: A trigger that comes between decimation points returns the most recent complete result. Triggers on consecutive cycles each give a strobe carrying that result.
- R9: The comparator filter uses ratio `cmpOsr` (4 to 32). A trusted comparator output greater than `highThr` sets `flagHigh`. One less than `lowThr` sets `flagLow`. Both comparisons are signed.
- R10: `flagZero` is set when two consecutive trusted comparator outputs differ in sign. Zero counts as non-negative.
- R11: Flags are sticky. Moving the thresholds leaves them set. A one-cycle `flagClr` pulse on a channel clears that channel's flags.
- R12: A modulator bit is taken on a rising edge of its `modClk`, after a two-stage synchronizer in front of both the clock and the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modClk | input | NCH | Modulator clock, one per channel |
| modData | input | NCH | Modulator bit, one per channel |
| pwmTrig | input | 1 | PWM-centre capture pulse |
| primOsr | input | OSR_W | Primary decimation ratio |
| cmpOsr | input | OSR_W | Comparator decimation ratio |
| highThr | input | W | Signed over-current threshold |
| lowThr | input | W | Signed under-current threshold |
| flagClr | input | NCH | Per-channel flag clear |
| dataOut | output | NCH×W | Captured signed results |
| dataValid | output | NCH | One-cycle capture strobe per channel |
| flagHigh | output | NCH | Sticky over-threshold flags |
| flagLow | output | NCH | Sticky under-threshold flags |
| flagZero | output | NCH | Sticky zero-crossing flags |

## Verification
The bench builds the block with its defaults: four channels, OSR_MAX of 32 and therefore 17-bit words. This puts the full-scale values ±32768 at ratio 32 and ±4096 at ratio 16 within reach, with no wrap. A comparator ratio of 8 keeps each comparator decimation to 32 system clocks. Flag setting, sign changes and clearing can then be seen within a few hundred cycles. Because all four channels carry distinct steady patterns, one capture checks full scale, density scaling and channel independence at once.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic bitStb;     // new modulator bit this cycle
    logic bitVal;     // its value
    logic primDump;   // primary decimation point
    logic primTrust;  // primary filter has settled
    logic primFlush;  // primary ratio changed
    logic cmpDump;    // comparator decimation point
    logic cmpTrust;   // comparator filter has settled
    logic cmpFlush;   // comparator ratio changed
    logic capture;    // PWM-centre capture request
  } chanCtl_t;
endpackage

// File: rtl/sdf_sinc3.sv
module sdf_sinc3 #(
  parameter int W = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bitStb,
  input  logic                bitVal,
  input  logic                dump,
  input  logic                trust,
  output logic signed [W-1:0] result,
  output logic                fresh
);
  logic signed [W-1:0] x, i1, i2, i3, d1, d2, d3, c1, c2, c3;

  assign x  = bitVal ? {{(W-1){1'b0}}, 1'b1} : {W{1'b1}};
  assign c1 = i3 - d1;
  assign c2 = c1 - d2;
  assign c3 = c2 - d3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i1 <= '0; i2 <= '0; i3 <= '0;
      d1 <= '0; d2 <= '0; d3 <= '0;
      result <= '0;
      fresh  <= 1'b0;
    end else begin
      if (bitStb) begin
        i1 <= i1 + x;
        i2 <= i2 + i1;
        i3 <= i3 + i2;
      end
      if (dump) begin
        d1 <= i3;
        d2 <= c1;
        d3 <= c2;
        result <= c3;
      end
      fresh <= dump & trust;
    end
  end
endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int OSR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            modClk,
  input  logic [NCH-1:0]            modData,
  input  logic                      pwmTrig,
  input  logic [OSR_W-1:0]          primOsr,
  input  logic [OSR_W-1:0]          cmpOsr,
  output chanCtl_t [NCH-1:0]        ctl
);
  localparam logic [OSR_W-1:0] ONE     = 1;
  localparam logic [1:0]       SETTLED = 2'd3;

  logic [OSR_W-1:0] primPrev, cmpPrev;
  logic             primChg, cmpChg;

  assign primChg = (primOsr != primPrev);
  assign cmpChg  = (cmpOsr != cmpPrev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primPrev <= '0;
      cmpPrev  <= '0;
    end else begin
      primPrev <= primOsr;
      cmpPrev  <= cmpOsr;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [2:0]       ckPipe;
    logic [1:0]       dPipe;
    logic [OSR_W-1:0] primCnt, cmpCnt;
    logic [1:0]       primSeen, cmpSeen;
    logic             rise, primEnd, cmpEnd;
    chanCtl_t         c;

    assign rise    = ckPipe[1] & ~ckPipe[2];
    assign primEnd = (primCnt == primOsr - ONE);
    assign cmpEnd  = (cmpCnt == cmpOsr - ONE);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ckPipe <= '0;
        dPipe  <= '0;
      end else begin
        ckPipe <= {ckPipe[1:0], modClk[g]};
        dPipe  <= {dPipe[0], modData[g]};
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || primChg) begin
        primCnt  <= '0;
        primSeen <= '0;
      end else if (rise) begin
        if (primEnd) begin
          primCnt <= '0;
          if (primSeen != SETTLED) primSeen <= primSeen + 2'd1;
        end else begin
          primCnt <= primCnt + ONE;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || cmpChg) begin
        cmpCnt  <= '0;
        cmpSeen <= '0;
      end else if (rise) begin
        if (cmpEnd) begin
          cmpCnt <= '0;
          if (cmpSeen != SETTLED) cmpSeen <= cmpSeen + 2'd1;
        end else begin
          cmpCnt <= cmpCnt + ONE;
        end
      end
    end

    always_comb begin
      c.bitStb    = rise;
      c.bitVal    = dPipe[1];
      c.primDump  = rise & primEnd & ~primChg;
      c.primTrust = (primSeen == SETTLED);
      c.primFlush = primChg;
      c.cmpDump   = rise & cmpEnd & ~cmpChg;
      c.cmpTrust  = (cmpSeen == SETTLED);
      c.cmpFlush  = cmpChg;
      c.capture   = pwmTrig;
    end

    assign ctl[g] = c;
  end
endmodule

// File: rtl/sdf_datapath.sv
module sdf_datapath
  import sdf_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 17
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  chanCtl_t [NCH-1:0]        ctl,
  input  logic signed [W-1:0]       highThr,
  input  logic signed [W-1:0]       lowThr,
  input  logic [NCH-1:0]            flagClr,
  output logic [NCH-1:0][W-1:0]     dataOut,
  output logic [NCH-1:0]            dataValid,
  output logic [NCH-1:0]            flagHigh,
  output logic [NCH-1:0]            flagLow,
  output logic [NCH-1:0]            flagZero
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic signed [W-1:0] pRes, cRes, held, outReg;
    logic                pFresh, cFresh, have, vld;
    logic                hi, lo, zc, prevSign, prevOk;

    sdf_sinc3 #(.W(W)) u_prim (
      .clk(clk), .rst_n(rst_n),
      .bitStb(ctl[g].bitStb), .bitVal(ctl[g].bitVal),
      .dump(ctl[g].primDump), .trust(ctl[g].primTrust),
      .result(pRes), .fresh(pFresh)
    );

    sdf_sinc3 #(.W(W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .bitStb(ctl[g].bitStb), .bitVal(ctl[g].bitVal),
      .dump(ctl[g].cmpDump), .trust(ctl[g].cmpTrust),
      .result(cRes), .fresh(cFresh)
    );

    // Primary: hold last trusted result, hand it out on capture
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held   <= '0;
        have   <= 1'b0;
        outReg <= '0;
        vld    <= 1'b0;
      end else begin
        if (pFresh) begin
          held <= pRes;
          have <= 1'b1;
        end
        if (ctl[g].primFlush) have <= 1'b0;
        vld <= 1'b0;
        if (ctl[g].capture && have) begin
          outReg <= held;
          vld    <= 1'b1;
        end
      end
    end

    // Comparator: sticky threshold and sign-change flags
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi <= 1'b0; lo <= 1'b0; zc <= 1'b0;
        prevSign <= 1'b0;
        prevOk   <= 1'b0;
      end else begin
        if (flagClr[g]) begin
          hi <= 1'b0; lo <= 1'b0; zc <= 1'b0;
        end
        if (cFresh) begin
          if (cRes > highThr) hi <= 1'b1;
          if (cRes < lowThr)  lo <= 1'b1;
          if (prevOk && (cRes[W-1] != prevSign)) zc <= 1'b1;
          prevSign <= cRes[W-1];
          prevOk   <= 1'b1;
        end
        if (ctl[g].cmpFlush) prevOk <= 1'b0;
      end
    end

    assign dataOut[g]   = outReg;
    assign dataValid[g] = vld;
    assign flagHigh[g]  = hi;
    assign flagLow[g]   = lo;
    assign flagZero[g]  = zc;
  end
endmodule

// File: rtl/sdf_top.sv
module sdf_top
  import sdf_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int OSR_MAX = 32,
  localparam int OSR_W  = $clog2(OSR_MAX + 1),
  localparam int W      = 3 * $clog2(OSR_MAX) + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            modClk,
  input  logic [NCH-1:0]            modData,
  input  logic                      pwmTrig,
  input  logic [OSR_W-1:0]          primOsr,
  input  logic [OSR_W-1:0]          cmpOsr,
  input  logic signed [W-1:0]       highThr,
  input  logic signed [W-1:0]       lowThr,
  input  logic [NCH-1:0]            flagClr,
  output logic [NCH-1:0][W-1:0]     dataOut,
  output logic [NCH-1:0]            dataValid,
  output logic [NCH-1:0]            flagHigh,
  output logic [NCH-1:0]            flagLow,
  output logic [NCH-1:0]            flagZero
);
  chanCtl_t [NCH-1:0] ctl;

  sdf_ctrl #(.NCH(NCH), .OSR_W(OSR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .modClk(modClk), .modData(modData), .pwmTrig(pwmTrig),
    .primOsr(primOsr), .cmpOsr(cmpOsr),
    .ctl(ctl)
  );

  sdf_datapath #(.NCH(NCH), .W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .highThr(highThr), .lowThr(lowThr), .flagClr(flagClr),
    .dataOut(dataOut), .dataValid(dataValid),
    .flagHigh(flagHigh), .flagLow(flagLow), .flagZero(flagZero)
  );
endmodule

// File: rtl/sdf_chk.sv
module sdf_chk #(
  parameter int NCH = 4,
  parameter int W   = 17
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pwmTrig,
  input logic [NCH-1:0]        flagClr,
  input logic [NCH-1:0][W-1:0] dataOut,
  input logic [NCH-1:0]        dataValid,
  input logic [NCH-1:0]        flagHigh,
  input logic [NCH-1:0]        flagLow,
  input logic [NCH-1:0]        flagZero
);
  assert_strobe_follows_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dataValid) |-> $past(pwmTrig));

  assert_out_moves_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dataOut) |-> (|dataValid));

  assert_high_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((flagHigh & ~flagClr) != '0) |=> (($past(flagHigh & ~flagClr) & ~flagHigh) == '0));

  assert_low_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((flagLow & ~flagClr) != '0) |=> (($past(flagLow & ~flagClr) & ~flagLow) == '0));

  assert_zero_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((flagZero & ~flagClr) != '0) |=> (($past(flagZero & ~flagClr) & ~flagZero) == '0));
endmodule

bind sdf_top sdf_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwmTrig(pwmTrig), .flagClr(flagClr),
  .dataOut(dataOut), .dataValid(dataValid),
  .flagHigh(flagHigh), .flagLow(flagLow), .flagZero(flagZero)
);

// File: tb/tb_sdf_top.sv
`timescale 1ns/1ps
module tb_sdf_top;
  localparam int NCH = 4, OSR_MAX = 32, OSR_W = 6, W = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                     mck = 1'b0;
  logic [NCH-1:0]           modClk, modData = '0;
  logic                     pwmTrig = 1'b0;
  logic [OSR_W-1:0]         primOsr = 6'd32, cmpOsr = 6'd8;
  logic signed [W-1:0]      highThr = 17'sd400, lowThr = -17'sd400;
  logic [NCH-1:0]           flagClr = '0;
  logic [NCH-1:0][W-1:0]    dataOut;
  logic [NCH-1:0]           dataValid, flagHigh, flagLow, flagZero;

  assign modClk = {NCH{mck}};

  sdf_top #(.NCH(NCH), .OSR_MAX(OSR_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .modClk(modClk), .modData(modData),
    .pwmTrig(pwmTrig), .primOsr(primOsr), .cmpOsr(cmpOsr),
    .highThr(highThr), .lowThr(lowThr), .flagClr(flagClr),
    .dataOut(dataOut), .dataValid(dataValid),
    .flagHigh(flagHigh), .flagLow(flagLow), .flagZero(flagZero)
  );

  int checks = 0, fails = 0;
  int pat [NCH] = '{0, 1, 2, 3};
  int bitIdx = 0;
  int qCh[$], qVal[$];
  string qTag[$];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Pattern 0: ones, 1: zeros, 2: alternating 0,1, 3: repeating 1,1,1,0
  function automatic logic patBit(input int p, input int k);
    case (p)
      0: return 1'b1;
      1: return 1'b0;
      2: return k[0];
      default: return (k % 4) != 3;
    endcase
  endfunction

  // Modulator model (R12): data moves on the falling edge, 4 clocks per bit
  initial begin
    forever begin
      @(negedge clk); mck = 1'b1;
      @(negedge clk);
      @(negedge clk); mck = 1'b0;
      bitIdx++;
      for (int c = 0; c < NCH; c++) modData[c] = patBit(pat[c], bitIdx);
      @(negedge clk);
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (dataValid[c]) begin : m_pop
          logic signed [W-1:0] v;
          int ec, ev;
          string et;
          v = dataOut[c];
          if (qCh.size() == 0) begin
            check(1'b0, "R5 unexpected strobe", int'(v), -1);
          end else begin
            ec = qCh.pop_front();
            ev = qVal.pop_front();
            et = qTag.pop_front();
            check(ec == c && int'(v) == ev, et, int'(v), ev);
          end
        end
      end
    end
  end

  task automatic pushAll(input int ev [NCH], input string tag);
    for (int c = 0; c < NCH; c++) begin
      qCh.push_back(c);
      qVal.push_back(ev[c]);
      qTag.push_back(tag);
    end
  endtask

  task automatic fireExpect(input int ev [NCH], input string tag);
    pushAll(ev, tag);
    @(negedge clk); pwmTrig = 1'b1;
    @(negedge clk); pwmTrig = 1'b0;
    check(dataValid == '1, "R5 strobe after trigger", int'(dataValid), 15);
    @(negedge clk);
    check(dataValid == '0, "R5 strobe lasts one cycle", int'(dataValid), 0);
  endtask

  task automatic fireTwice(input int ev [NCH], input string tag);
    pushAll(ev, tag);
    pushAll(ev, tag);
    @(negedge clk); pwmTrig = 1'b1;
    @(negedge clk);
    @(negedge clk); pwmTrig = 1'b0;
    check(dataValid == '1, "R8 second strobe", int'(dataValid), 15);
    @(negedge clk);
    check(dataValid == '0, "R8 strobes end", int'(dataValid), 0);
  endtask

  task automatic fireNone(input string tag);
    @(negedge clk); pwmTrig = 1'b1;
    @(negedge clk); pwmTrig = 1'b0;
    check(dataValid == '0, tag, int'(dataValid), 0);
  endtask

  task automatic waitBits(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    // R1: reset state
    check(dataValid == '0, "R1 dataValid in reset", int'(dataValid), 0);
    check((flagHigh | flagLow | flagZero) == '0, "R1 flags in reset",
          int'(flagHigh | flagLow | flagZero), 0);
    check(dataOut == '0, "R1 dataOut in reset", int'(dataOut[0]), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    fireNone("R6 trigger before settling");

    waitBits(32 * 8);
    fireExpect('{32768, -32768, 0, 16384}, "R2,R3,R4,R12 ratio 32");
    waitBits(5);
    fireExpect('{32768, -32768, 0, 16384}, "R8 mid-decimation capture");
    fireTwice('{32768, -32768, 0, 16384}, "R8 back-to-back capture");

    // Comparator at ratio 8: ch0 +512, ch1 -512, ch2 0, ch3 +256
    check(flagHigh == 4'b0001, "R9 high flags", int'(flagHigh), 1);
    check(flagLow == 4'b0010, "R9 low flags", int'(flagLow), 2);
    check(flagZero == 4'b0000, "R10 no crossing", int'(flagZero), 0);

    highThr = 17'sd1000; lowThr = -17'sd1000;
    waitBits(8 * 6);
    check(flagHigh == 4'b0001 && flagLow == 4'b0010, "R11 sticky after threshold move",
          int'({flagHigh, flagLow}), 8'h12);
    @(negedge clk); flagClr = '1;
    @(negedge clk); flagClr = '0;
    waitBits(8 * 6);
    check((flagHigh | flagLow | flagZero) == '0, "R11 cleared",
          int'(flagHigh | flagLow | flagZero), 0);

    // R7: ratio change
    @(negedge clk); primOsr = 6'd16;
    @(negedge clk);
    fireNone("R7 trigger after ratio change");
    waitBits(16 * 6);
    fireExpect('{4096, -4096, 0, 2048}, "R7 ratio 16");

    // Swap ch0 and ch1 streams
    pat[0] = 1; pat[1] = 0;
    waitBits(16 * 6);
    fireExpect('{-4096, 4096, 0, 2048}, "R4 swapped streams");
    check(flagZero == 4'b0011, "R10 sign change flags", int'(flagZero), 3);
    check((flagHigh | flagLow) == '0, "R9 thresholds out of reach",
          int'(flagHigh | flagLow), 0);

    highThr = 17'sd400; lowThr = -17'sd400;
    waitBits(8 * 5);
    check(flagHigh == 4'b0010, "R9 high after swap", int'(flagHigh), 2);
    check(flagLow == 4'b0001, "R9 low after swap", int'(flagLow), 1);

    repeat (4) @(negedge clk);
    check(qCh.size() == 0, "R5 all expected strobes seen", qCh.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule